// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog counter that advances once per state time and raises a one-clock reset request when it wraps past its all-ones value. Software keeps it from firing by clearing it through a byte-wide register-write port. A clear only takes effect after a two-write unlock sequence to one fixed address: a first key byte, then a second key byte. Any other write, or an acknowledged interrupt, between the two keys breaks the sequence.

A mode input chosen at reset decides whether the watchdog runs straight away or stays dormant until software clears it for the first time. Once it is running, only a reset stops it. An idle-mode indication is accepted but deliberately has no effect, so a device asleep too long is still reset. Generating the actual reset pulse and decoding the processor bus are left to the surrounding logic.

Top module: `keyed_wdt`

## Requirements
- R1: The counter is CNT_W bits wide (16 by default) and advances by one only on clock edges where tick_i is 1 and the watchdog is active; it holds otherwise.
- R2: When an active counter at its all-ones value takes a tick, it wraps to zero and wdt_rst_o is 1 for exactly one clock in the following cycle, so pulses repeat every 2^CNT_W ticks while no clear occurs.
- R3: On the first clock edge after rst_ni is released, dormant_cfg_i is sampled: 0 makes the watchdog active from that edge, 1 makes it dormant.
- R4: While dormant, the counter is held at zero and wdt_rst_o stays 0; wdt_rst_o is 0 during and right after reset.
- R5: A clear is a write of 0x1E to address 0x0A followed by a write of 0xE1 to address 0x0A; on the edge of the second write the counter becomes zero and a dormant watchdog becomes active. A clear on the same edge as a wrap suppresses that wrap's pulse.
- R6: A write between the two keys that is not the first key (wrong data or another address) aborts the sequence, and the keys in reversed order do not clear.
- R7: irq_ack_i high in any cycle aborts a pending sequence, and a second-key write in the same cycle as irq_ack_i does not clear.
- R8: Cycles without a write between the two keys do not break the sequence, and a repeated first-key write re-arms the first step.
- R9: Once active, the watchdog stays active regardless of dormant_cfg_i until rst_ni is asserted; after a reset it follows dormant_cfg_i again.
- R10: idle_i has no effect: the counter keeps advancing and overflowing while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | State-time strobe, one count per high cycle |
| dormant_cfg_i | input | 1 | Reset-time mode: 1 = dormant until first clear |
| idle_i | input | 1 | Device idle indication (counting continues) |
| irq_ack_i | input | 1 | Interrupt acknowledge; breaks a key sequence |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| wdt_rst_o | output | 1 | One-clock overflow reset request |

## Verification
The bench uses an 8-bit counter so every overflow interval can be timed edge by edge, and it predicts each pulse as a fixed distance in clock edges from the last clear, the last wrap or the boot edge. Key streams are varied one element at a time: correct order, reversed order, a wrong byte or wrong address in the middle, an interrupt between or on the second key, idle gaps, and a repeated first key. Each bad stream leaves the previous pulse spacing intact while each good one moves it, which is what tells them apart. Half-rate ticking, idle mode, a clear landing on the wrap edge and both reset modes separate the counting, suppression and activation paths.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  typedef enum logic [1:0] {
    WDT_BOOT    = 2'd0,
    WDT_DORMANT = 2'd1,
    WDT_ACTIVE  = 2'd2
  } wdt_state_e;
endpackage

// File: rtl/keyed_wdt_key_seq.sv
module keyed_wdt_key_seq #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h0A,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              irq_ack_i,
  output logic              armed_o,
  output logic              clear_o
);
  logic armed_q;
  logic hit_addr, hit_first, hit_second;

  assign hit_addr   = wr_en_i && (wr_addr_i == KEY_ADDR);
  assign hit_first  = hit_addr && (wr_data_i == KEY_FIRST);
  assign hit_second = hit_addr && (wr_data_i == KEY_SECOND);

  // interrupt wins over any write in the same cycle
  assign clear_o = armed_q && hit_second && !irq_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (irq_ack_i) begin
      armed_q <= 1'b0;
    end else if (wr_en_i) begin
      armed_q <= hit_first;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/keyed_wdt_mode.sv
module keyed_wdt_mode
  import keyed_wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dormant_cfg_i,
  input  logic       clear_i,
  output wdt_state_e state_o,
  output logic       active_o
);
  wdt_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WDT_BOOT:    state_d = (clear_i || !dormant_cfg_i) ? WDT_ACTIVE : WDT_DORMANT;
      WDT_DORMANT: if (clear_i) state_d = WDT_ACTIVE;
      WDT_ACTIVE:  state_d = WDT_ACTIVE;
      default:     state_d = WDT_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WDT_BOOT;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign active_o = (state_q == WDT_ACTIVE);
endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = run_i && tick_i && !clear_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (!run_i || clear_i) cnt_q <= '0;
      else if (tick_i)       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] WDT_ADDR   = 8'h0A,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              dormant_cfg_i,
  input  logic              idle_i,
  input  logic              irq_ack_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wdt_rst_o
);
  logic             key_clear, key_armed, mode_active;
  wdt_state_e       mode_state;
  logic [CNT_W-1:0] cnt_val;

  keyed_wdt_key_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(WDT_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_key (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .irq_ack_i,
    .armed_o(key_armed), .clear_o(key_clear)
  );

  keyed_wdt_mode u_mode (
    .clk_i, .rst_ni, .dormant_cfg_i,
    .clear_i(key_clear), .state_o(mode_state), .active_o(mode_active)
  );

  // idle_i intentionally does not gate counting
  keyed_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(mode_active), .tick_i,
    .clear_i(key_clear), .count_o(cnt_val), .ovf_o(wdt_rst_o)
  );
endmodule

// File: rtl/keyed_wdt_checker.sv
module keyed_wdt_checker
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             idle_i,
  input logic             irq_ack_i,
  input logic             wdt_rst_o,
  input wdt_state_e       mode_state,
  input logic [CNT_W-1:0] cnt_val,
  input logic             key_clear,
  input logic             key_armed
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_state == WDT_ACTIVE && tick_i && !key_clear) |=> (cnt_val == $past(cnt_val) + 1'b1));

  p_cnt_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_state == WDT_ACTIVE && !tick_i && !key_clear) |=> $stable(cnt_val));

  p_pulse_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  p_pulse_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> ($past(cnt_val) == CNT_MAX && cnt_val == '0));

  p_dormant_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_state == WDT_DORMANT) |=> (!wdt_rst_o && cnt_val == '0));

  p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_clear |=> (cnt_val == '0 && mode_state == WDT_ACTIVE && !wdt_rst_o));

  p_irq_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |-> !key_clear ##1 !key_armed);

  p_active_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_state == WDT_ACTIVE) |=> (mode_state == WDT_ACTIVE));

  p_idle_counts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && mode_state == WDT_ACTIVE && tick_i && !key_clear) |=> (cnt_val != $past(cnt_val)));
endmodule

bind keyed_wdt keyed_wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .idle_i, .irq_ack_i, .wdt_rst_o,
  .mode_state, .cnt_val, .key_clear, .key_armed
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int P = 1 << W;
  localparam logic [7:0] A_WDT = 8'h0A, K1 = 8'h1E, K2 = 8'hE1;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b1, cfg = 1'b1, idle_i = 1'b0, irq = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic wdt_rst_o;
  logic half_rate = 1'b0;
  int cyc = 0, n_tests = 0, n_fail = 0;
  int ref_c, at;

  keyed_wdt #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni, .tick_i, .dormant_cfg_i(cfg), .idle_i, .irq_ack_i(irq),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wdt_rst_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick_i <= half_rate ? ~tick_i : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns edge index of next pulse, -1 on timeout
  task automatic wait_pulse(input int limit, output int t);
    t = -1;
    for (int n = 0; n < limit; n++) begin
      if (wdt_rst_o) begin t = cyc; return; end
      @(negedge clk);
    end
  endtask

  task automatic count_pulses(input int span, output int k);
    k = 0;
    for (int n = 0; n < span; n++) begin
      @(negedge clk);
      if (wdt_rst_o) k++;
    end
  endtask

  task automatic expect_gap(input string req, input int from, input int gap);
    wait_pulse(3 * P, at);
    check(at - from == gap, req, at - from, gap);
    @(negedge clk);
    ref_c = at;
  endtask

  initial begin
    int k;
    @(negedge clk); @(negedge clk);
    check(wdt_rst_o == 1'b0, "R4 reset state", wdt_rst_o, 0);
    rst_ni = 1'b1;

    // R3/R4: dormant mode, no pulse
    count_pulses(3 * P, k);
    check(k == 0, "R4 dormant silent", k, 0);

    // R5: first clear activates
    wr(A_WDT, K1); wr(A_WDT, K2); ref_c = cyc;
    wait_pulse(3 * P, at);
    check(at - ref_c == P, "R5 activation by clear", at - ref_c, P);
    @(negedge clk);
    check(wdt_rst_o == 1'b0, "R2 one-clock pulse", wdt_rst_o, 0);
    ref_c = at;
    expect_gap("R2 wrap period", ref_c, P);

    // R8: idle gap between keys still clears
    repeat (40) @(negedge clk);
    wr(A_WDT, K1); repeat (3) @(negedge clk); wr(A_WDT, K2);
    expect_gap("R8 gap between keys", cyc, P);

    // R6: reversed order
    repeat (10) @(negedge clk);
    wr(A_WDT, K2); wr(A_WDT, K1); wr(A_WDT, 8'h00);
    expect_gap("R6 reversed keys", ref_c, P);

    // R6: wrong data between
    repeat (10) @(negedge clk);
    wr(A_WDT, K1); wr(A_WDT, 8'h55); wr(A_WDT, K2);
    expect_gap("R6 wrong data between", ref_c, P);

    // R6: second key to another address
    repeat (10) @(negedge clk);
    wr(A_WDT, K1); wr(8'h0B, K2);
    expect_gap("R6 wrong address", ref_c, P);

    // R6: write elsewhere between keys
    repeat (10) @(negedge clk);
    wr(A_WDT, K1); wr(8'h20, K1); wr(A_WDT, K2);
    expect_gap("R6 foreign write between", ref_c, P);

    // R7: interrupt between keys
    repeat (10) @(negedge clk);
    wr(A_WDT, K1);
    irq = 1'b1; @(negedge clk); irq = 1'b0;
    wr(A_WDT, K2);
    expect_gap("R7 interrupt between", ref_c, P);

    // R7: interrupt on the second key
    repeat (10) @(negedge clk);
    wr(A_WDT, K1);
    irq = 1'b1; wr(A_WDT, K2); irq = 1'b0;
    expect_gap("R7 interrupt with second key", ref_c, P);

    // R8: repeated first key re-arms
    repeat (10) @(negedge clk);
    wr(A_WDT, K1); wr(A_WDT, K1); wr(A_WDT, K2);
    expect_gap("R8 re-armed first key", cyc, P);

    // R5: clear on the wrap edge suppresses the pulse
    wr(A_WDT, K1);
    while (cyc < ref_c + P - 1) @(negedge clk);
    wr(A_WDT, K2);
    check(cyc == ref_c + P, "R5 clear timing setup", cyc, ref_c + P);
    expect_gap("R5 clear beats wrap", ref_c, 2 * P);

    // R10: idle has no effect
    idle_i = 1'b1;
    expect_gap("R10 overflow while idle", ref_c, P);
    idle_i = 1'b0;

    // R9: mode input ignored while active
    cfg = 1'b0; repeat (5) @(negedge clk); cfg = 1'b1;
    expect_gap("R9 config change ignored", ref_c, P);

    // R1: half-rate ticks double the interval
    half_rate = 1'b1;
    wait_pulse(3 * P, at);
    check((at - ref_c == 2 * P) || (at - ref_c == 2 * P - 1), "R1 tick gating", at - ref_c, 2 * P);
    @(negedge clk);
    half_rate = 1'b0;

    // R3: reset with active mode runs from boot edge
    rst_ni = 1'b0; cfg = 1'b0;
    @(negedge clk); @(negedge clk);
    check(wdt_rst_o == 1'b0, "R4 reset clears pulse", wdt_rst_o, 0);
    rst_ni = 1'b1; ref_c = cyc + 1;
    expect_gap("R3 active from reset", ref_c, P);

    // R9: reset deactivates; dormant again
    rst_ni = 1'b0; cfg = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    count_pulses(2 * P + 10, k);
    check(k == 0, "R9 reset returns to dormant", k, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule